// File: doc/BRIEF.md
# Two-Port USB Root Hub Port Status Logic

This block holds the status word of each downstream root hub port of a full/low-speed USB host controller, together with the controller's interrupt status and enable words. Events from the port side (a device arriving, a device leaving, the over-current sense line) and word writes from a simple memory-mapped bus update the port words. Each tracked condition has a sticky change flag beside it. Software clears a change flag by writing a one to it.

Whenever a port-side event really alters a port word, the block latches the root-hub status-change bit in the interrupt status word. A single interrupt line is derived from the status word, the enable word and a master enable bit. A controller reset request runs a short sequence. The sequence first zeroes every port word. It then replays the arrival of each device that is still plugged in.

The sequencer has three states. In HC_RUN the block runs normally. In HC_CLEAR the port words are wiped. In HC_REATTACH the present devices are replayed. Its transitions are: HC_RUN to HC_CLEAR on a reset request, HC_CLEAR to HC_REATTACH unconditionally, and HC_REATTACH to HC_RUN unconditionally. Each port has its own two-state machine. PT_IDLE moves to PT_RESETTING on an accepted port-reset command. PT_RESETTING returns to PT_IDLE once the reset interval has elapsed, or on a controller clear.

Top module: `usb_rh_port_status`

## Requirements
- R1: After reset every port word, the interrupt status word and the interrupt enable word read zero, and the interrupt line is low.
- R2: The bus word addresses are: 0 interrupt status, 1 enable-set (reads the enable word), 2 enable-clear (reads the enable word), and 3+i for the status word of port i. Unmapped addresses read zero.
- R3: Port word bits: 0 connected, 1 enabled, 2 suspended, 3 over-current, 4 reset active, 8 powered, 9 low-speed device. An attach sets bit 0 and change flag bit 16, and copies the low-speed input into bit 9.
- R4: A detach clears bit 0 and sets bit 16 only if bit 0 was set. It clears bit 1 and sets bit 17 only if bit 1 was set. A detach on an idle port leaves the word and bit 6 of the interrupt status untouched.
- R5: Change flags are bit 16 connect, 17 enable, 18 suspend, 19 over-current and 20 reset. Writing one clears a flag and writing zero keeps it. Writing bit 0 or bit 9 has no effect.
- R6: Writing one to bit 1 enables a connected port. Writing one to bit 2 suspends an enabled port. Writing one to bit 3 resumes a suspended port and sets bit 18. Writing one to bit 8 sets power.
- R7: Writing one to bit 4 on a connected port that is not already resetting raises bit 4 for RST_CYCLES cycles. At the end, bit 4 clears, bit 20 sets, bit 2 clears, and bit 1 sets if the port is still connected.
- R8: Bit 3 follows the port's over-current input. Each change of the input sets bit 19.
- R9: Interrupt status bits 0 to 6 and 30 latch from the source input or the hub, and other source bits are dropped. A port-side event that changes a port word sets bit 6. Writing one to address 0 clears a bit, and a new event in the same cycle wins over the clear.
- R10: The interrupt line is high exactly when enable bit 31 is set and status AND enable is nonzero in bits 0 to 30.
- R11: A reset request in HC_RUN zeroes all port words on the next edge. One edge later it rewrites each present device's port word as bits 0, 16 and the device's low-speed bit 9, and sets interrupt bit 6.
- R12: Within one cycle a bus write to a port word is applied before that port's events. A detach wins over a simultaneous attach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hc_reset_i | input | 1 | Controller reset request pulse |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Bus word address |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data, combinational from address |
| dev_attach_i | input | N_PORTS | Per-port device attach pulse |
| dev_detach_i | input | N_PORTS | Per-port device detach pulse |
| dev_lowspeed_i | input | N_PORTS | Per-port speed of the attaching device, 1 = low speed |
| port_oc_i | input | N_PORTS | Per-port over-current sense level |
| int_src_i | input | 32 | Other controller interrupt event bits, one-cycle pulses |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench targets these corner cases:

- A second detach on a port that is already empty. A design that raised the status-change interrupt unconditionally would latch bit 6 here.
- A one written to a change flag in the same cycle as an attach. A design that applied the clear after the event would lose the connect change.
- Writes to the connected and low-speed bits. A design that did not protect them would corrupt them.
- The exact cycle on which a port reset ends. An off-by-one counter shows up as a word that still carries, or has already lost, the reset bit.
- A controller reset with a device still present. A missed replay leaves that port dark.

// File: rtl/rh_pkg.sv
package rh_pkg;
    // Port status word bit positions (software-visible layout)
    localparam int PB_CONN     = 0;
    localparam int PB_ENA      = 1;
    localparam int PB_SUSP     = 2;
    localparam int PB_OVC      = 3;
    localparam int PB_RSTA     = 4;
    localparam int PB_PWR      = 8;
    localparam int PB_LOWSPD   = 9;
    localparam int PB_CONN_CHG = 16;
    localparam int PB_ENA_CHG  = 17;
    localparam int PB_SUSP_CHG = 18;
    localparam int PB_OVC_CHG  = 19;
    localparam int PB_RST_CHG  = 20;

    // Interrupt word
    localparam int IB_HUBCHG   = 6;
    localparam int IB_MASTER   = 31;
    localparam logic [31:0] INT_LATCHABLE = 32'h4000_007F;
    localparam logic [31:0] INT_NO_MASTER = 32'h7FFF_FFFF;

    // Bus map
    localparam int A_INT_STAT = 0;
    localparam int A_EN_SET   = 1;
    localparam int A_EN_CLR   = 2;
    localparam int A_PORT0    = 3;

    typedef enum logic [1:0] {
        HC_RUN      = 2'd0,
        HC_CLEAR    = 2'd1,
        HC_REATTACH = 2'd2
    } hc_state_t;

    typedef enum logic {
        PT_IDLE      = 1'b0,
        PT_RESETTING = 1'b1
    } pt_state_t;
endpackage

// File: rtl/rh_hc_seq.sv
module rh_hc_seq
    import rh_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic run_o,
    output logic clear_o,
    output logic replay_o
);
    hc_state_t state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= HC_RUN;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HC_RUN:      if (req_i) state_d = HC_CLEAR;
            HC_CLEAR:    state_d = HC_REATTACH;
            HC_REATTACH: state_d = HC_RUN;
            default:     state_d = HC_RUN;
        endcase
    end

    always_comb begin
        run_o    = (state_q == HC_RUN);
        clear_o  = (state_q == HC_CLEAR);
        replay_o = (state_q == HC_REATTACH);
    end

    // R11: wipe is always followed by the replay step
    p_clear_then_replay_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == HC_CLEAR) |=> (state_q == HC_REATTACH));
    p_req_starts_seq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == HC_RUN && req_i) |=> (state_q == HC_CLEAR));
endmodule

// File: rtl/rh_irq.sv
module rh_irq
    import rh_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_stat_i,
    input  logic        wr_set_i,
    input  logic        wr_clr_i,
    input  logic [31:0] wdata_i,
    input  logic [31:0] src_i,
    input  logic        hubchg_i,
    output logic [31:0] stat_o,
    output logic [31:0] en_o,
    output logic        irq_o
);
    logic [31:0] stat_q, stat_d, en_q, en_d, hub_bit;

    always_comb begin
        hub_bit = '0;
        hub_bit[IB_HUBCHG] = hubchg_i;
        stat_d = stat_q;
        if (wr_stat_i) stat_d = stat_d & ~wdata_i;
        stat_d = stat_d | (src_i & INT_LATCHABLE) | hub_bit;
        en_d = en_q;
        if (wr_set_i) en_d = en_d | wdata_i;
        if (wr_clr_i) en_d = en_d & ~wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= stat_d;
            en_q   <= en_d;
        end
    end

    always_comb begin
        stat_o = stat_q;
        en_o   = en_q;
        irq_o  = en_q[IB_MASTER] && (|(stat_q & en_q & INT_NO_MASTER));
    end

    // R9: a hub event is latched on the next edge
    p_hub_latched_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hubchg_i |=> stat_q[IB_HUBCHG]);
    // R9: latched bit only leaves through a write of one
    p_hub_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_q[IB_HUBCHG] && !(wr_stat_i && wdata_i[IB_HUBCHG])) |=> stat_q[IB_HUBCHG]);
    // R9: bits outside the latchable set never appear
    p_no_stray_bits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((stat_q & ~INT_LATCHABLE) == '0));
endmodule

// File: rtl/rh_port.sv
module rh_port
    import rh_pkg::*;
#(
    parameter int RST_CYCLES = 10
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        run_i,
    input  logic        clear_i,
    input  logic        replay_i,
    input  logic        wr_i,
    input  logic [31:0] wdata_i,
    input  logic        attach_i,
    input  logic        detach_i,
    input  logic        lowspeed_i,
    input  logic        oc_i,
    output logic [31:0] status_o,
    output logic        chg_evt_o
);
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

    pt_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [31:0]      stat_q, stat_d, after_wr;
    logic             present_q, ls_q, evt;

    // device presence, tracked in every sequencer state
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            present_q <= 1'b0;
            ls_q      <= 1'b0;
        end else if (detach_i) begin
            present_q <= 1'b0;
        end else if (attach_i) begin
            present_q <= 1'b1;
            ls_q      <= lowspeed_i;
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q   <= PT_IDLE;
            cnt_q  <= '0;
            stat_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            stat_q <= stat_d;
        end
    end

    // next state and status word
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        after_wr = stat_q;
        stat_d   = stat_q;
        evt      = 1'b0;
        if (clear_i) begin
            stat_d = '0;
            st_d   = PT_IDLE;
            cnt_d  = '0;
        end else if (replay_i) begin
            stat_d = '0;
            if (present_q) begin
                stat_d[PB_CONN]     = 1'b1;
                stat_d[PB_CONN_CHG] = 1'b1;
                stat_d[PB_LOWSPD]   = ls_q;
                evt                 = 1'b1;
            end
        end else if (run_i) begin
            // software commands first
            if (wr_i) begin
                after_wr[PB_RST_CHG:PB_CONN_CHG] =
                    after_wr[PB_RST_CHG:PB_CONN_CHG] & ~wdata_i[PB_RST_CHG:PB_CONN_CHG];
                if (wdata_i[PB_PWR]) after_wr[PB_PWR] = 1'b1;
                if (wdata_i[PB_ENA] && stat_q[PB_CONN]) after_wr[PB_ENA] = 1'b1;
                if (wdata_i[PB_SUSP] && stat_q[PB_ENA]) after_wr[PB_SUSP] = 1'b1;
                if (wdata_i[PB_OVC] && stat_q[PB_SUSP]) begin
                    after_wr[PB_SUSP]     = 1'b0;
                    after_wr[PB_SUSP_CHG] = 1'b1;
                end
                if (wdata_i[PB_RSTA] && stat_q[PB_CONN] && st_q == PT_IDLE) begin
                    after_wr[PB_RSTA] = 1'b1;
                    st_d  = PT_RESETTING;
                    cnt_d = CNT_LOAD;
                end
            end
            stat_d = after_wr;
            // port-side events next
            unique case (st_q)
                PT_IDLE: begin
                end
                PT_RESETTING: begin
                    if (cnt_q == '0) begin
                        stat_d[PB_RSTA]    = 1'b0;
                        stat_d[PB_RST_CHG] = 1'b1;
                        stat_d[PB_SUSP]    = 1'b0;
                        if (stat_d[PB_CONN]) stat_d[PB_ENA] = 1'b1;
                        st_d = PT_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: st_d = PT_IDLE;
            endcase
            if (oc_i != stat_d[PB_OVC]) begin
                stat_d[PB_OVC]     = oc_i;
                stat_d[PB_OVC_CHG] = 1'b1;
            end
            if (detach_i) begin
                if (stat_d[PB_CONN]) begin
                    stat_d[PB_CONN]     = 1'b0;
                    stat_d[PB_CONN_CHG] = 1'b1;
                end
                if (stat_d[PB_ENA]) begin
                    stat_d[PB_ENA]     = 1'b0;
                    stat_d[PB_ENA_CHG] = 1'b1;
                end
            end else if (attach_i) begin
                stat_d[PB_CONN]     = 1'b1;
                stat_d[PB_CONN_CHG] = 1'b1;
                stat_d[PB_LOWSPD]   = lowspeed_i;
            end
            evt = (stat_d != after_wr);
        end
    end

    always_comb begin
        status_o  = stat_q;
        chg_evt_o = evt;
    end

    // R4: a detach in normal operation always leaves the port disconnected
    p_detach_drops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && detach_i) |=> (!stat_q[PB_CONN] && !stat_q[PB_ENA]));
    // R3: an attach (without a detach) shows up with its change flag
    p_attach_shows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && attach_i && !detach_i) |=> (stat_q[PB_CONN] && stat_q[PB_CONN_CHG]));
    // R5: connect change flag survives unless a one is written to it
    p_chg_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && stat_q[PB_CONN_CHG] && !(wr_i && wdata_i[PB_CONN_CHG])) |=> stat_q[PB_CONN_CHG]);
    // R7: the last reset cycle ends reset and flags it
    p_reset_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && st_q == PT_RESETTING && cnt_q == '0) |=> (!stat_q[PB_RSTA] && stat_q[PB_RST_CHG]));
endmodule

// File: rtl/usb_rh_port_status.sv
module usb_rh_port_status
    import rh_pkg::*;
#(
    parameter int N_PORTS    = 2,
    parameter int RST_CYCLES = 10,
    localparam int ADDR_W    = $clog2(A_PORT0 + N_PORTS)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               hc_reset_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    input  logic [N_PORTS-1:0] dev_attach_i,
    input  logic [N_PORTS-1:0] dev_detach_i,
    input  logic [N_PORTS-1:0] dev_lowspeed_i,
    input  logic [N_PORTS-1:0] port_oc_i,
    input  logic [31:0]        int_src_i,
    output logic               irq_o
);
    logic                          seq_run, seq_clear, seq_replay;
    logic [N_PORTS-1:0][31:0]      port_stat;
    logic [N_PORTS-1:0]            port_evt;
    logic [N_PORTS-1:0]            port_wr;
    logic [31:0]                   int_stat, int_en;

    rh_hc_seq u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (hc_reset_i),
        .run_o    (seq_run),
        .clear_o  (seq_clear),
        .replay_o (seq_replay)
    );

    for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_port
        assign port_wr[gi] = bus_wr_i && (bus_addr_i == ADDR_W'(A_PORT0 + gi));
        rh_port #(.RST_CYCLES(RST_CYCLES)) u_port (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .run_i      (seq_run),
            .clear_i    (seq_clear),
            .replay_i   (seq_replay),
            .wr_i       (port_wr[gi]),
            .wdata_i    (bus_wdata_i),
            .attach_i   (dev_attach_i[gi]),
            .detach_i   (dev_detach_i[gi]),
            .lowspeed_i (dev_lowspeed_i[gi]),
            .oc_i       (port_oc_i[gi]),
            .status_o   (port_stat[gi]),
            .chg_evt_o  (port_evt[gi])
        );
    end

    rh_irq u_irq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_stat_i (bus_wr_i && bus_addr_i == ADDR_W'(A_INT_STAT)),
        .wr_set_i  (bus_wr_i && bus_addr_i == ADDR_W'(A_EN_SET)),
        .wr_clr_i  (bus_wr_i && bus_addr_i == ADDR_W'(A_EN_CLR)),
        .wdata_i   (bus_wdata_i),
        .src_i     (int_src_i),
        .hubchg_i  (|port_evt),
        .stat_o    (int_stat),
        .en_o      (int_en),
        .irq_o     (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(A_INT_STAT)) bus_rdata_o = int_stat;
        else if (bus_addr_i == ADDR_W'(A_EN_SET) || bus_addr_i == ADDR_W'(A_EN_CLR))
            bus_rdata_o = int_en;
        for (int i = 0; i < N_PORTS; i++) begin
            if (bus_addr_i == ADDR_W'(A_PORT0 + i)) bus_rdata_o = port_stat[i];
        end
    end

    // R11: the wipe step leaves every port word at zero
    p_clear_zeroes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_clear |=> (port_stat == '0));
    // R10: interrupt line never high without the master enable
    p_irq_master_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> int_en[IB_MASTER]);
endmodule

// File: tb/usb_rh_port_status_bench.sv
`timescale 1ns/100ps
module usb_rh_port_status_bench;
    localparam int CLK_P = 10;
    localparam int NP    = 2;
    localparam int RSTC  = 10;
    localparam int AW    = 3;

    logic clk = 1'b0, rst_n = 1'b0, hc_req = 1'b0, bwr = 1'b0;
    logic [AW-1:0] baddr = '0;
    logic [31:0] bwdata = '0, brdata, isrc = '0;
    logic [NP-1:0] att = '0, det = '0, lsp = '0, oc = '0;
    logic irq;

    usb_rh_port_status #(.N_PORTS(NP), .RST_CYCLES(RSTC)) u_usb_rh_port_status (
        .clk_i(clk), .rst_ni(rst_n), .hc_reset_i(hc_req), .bus_wr_i(bwr),
        .bus_addr_i(baddr), .bus_wdata_i(bwdata), .bus_rdata_o(brdata),
        .dev_attach_i(att), .dev_detach_i(det), .dev_lowspeed_i(lsp),
        .port_oc_i(oc), .int_src_i(isrc), .irq_o(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // reference state
    logic [31:0] m_stat [NP];
    bit          m_rs   [NP];
    int          m_cnt  [NP];
    bit          m_pres [NP];
    bit          m_ls   [NP];
    logic [31:0] m_ist, m_ien;
    int          m_hc;
    logic [31:0] rd_v [8];
    logic        irq_v;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(int a);
        if (a == 0) return m_ist;
        if (a == 1 || a == 2) return m_ien;
        if (a >= 3 && a < 3 + NP) return m_stat[a-3];
        return 32'h0;
    endfunction

    function automatic logic m_irq();
        return m_ien[31] && (|(m_ist & m_ien & 32'h7FFF_FFFF));
    endfunction

    task automatic read_all(string tag);
        bwr = 1'b0;
        for (int a = 0; a < 6; a++) begin
            baddr = AW'(a);
            #0.4;
            rd_v[a] = brdata;
            chk(tag, brdata, m_read(a));
        end
        irq_v = irq;
        chk(tag, {31'b0, irq}, {31'b0, m_irq()});
    endtask

    task automatic model_step();
        logic [31:0] s, e, n_stat [NP];
        bit n_rs [NP], n_pres [NP], n_ls [NP], hub;
        int n_cnt [NP];
        hub = 1'b0;
        for (int p = 0; p < NP; p++) begin
            n_stat[p] = m_stat[p]; n_rs[p] = m_rs[p]; n_cnt[p] = m_cnt[p];
            if (m_hc == 1) begin
                n_stat[p] = 0; n_rs[p] = 0; n_cnt[p] = 0;
            end else if (m_hc == 2) begin
                n_stat[p] = m_pres[p] ? (32'h0001_0001 | (32'(m_ls[p]) << 9)) : 32'h0;
                if (m_pres[p]) hub = 1'b1;
            end else begin
                s = m_stat[p];
                if (bwr && int'(baddr) == 3 + p) begin
                    s[20:16] = s[20:16] & ~bwdata[20:16];
                    if (bwdata[8]) s[8] = 1'b1;
                    if (bwdata[1] && m_stat[p][0]) s[1] = 1'b1;
                    if (bwdata[2] && m_stat[p][1]) s[2] = 1'b1;
                    if (bwdata[3] && m_stat[p][2]) begin s[2] = 1'b0; s[18] = 1'b1; end
                    if (bwdata[4] && m_stat[p][0] && !m_rs[p]) begin
                        s[4] = 1'b1; n_rs[p] = 1; n_cnt[p] = RSTC - 1;
                    end
                end
                e = s;
                if (m_rs[p]) begin
                    if (m_cnt[p] == 0) begin
                        e[4] = 0; e[20] = 1; e[2] = 0;
                        if (e[0]) e[1] = 1;
                        n_rs[p] = 0;
                    end else n_cnt[p] = m_cnt[p] - 1;
                end
                if (oc[p] != e[3]) begin e[3] = oc[p]; e[19] = 1; end
                if (det[p]) begin
                    if (e[0]) begin e[0] = 0; e[16] = 1; end
                    if (e[1]) begin e[1] = 0; e[17] = 1; end
                end else if (att[p]) begin
                    e[0] = 1; e[16] = 1; e[9] = lsp[p];
                end
                if (e != s) hub = 1'b1;
                n_stat[p] = e;
            end
            n_pres[p] = m_pres[p]; n_ls[p] = m_ls[p];
            if (det[p]) n_pres[p] = 0;
            else if (att[p]) begin n_pres[p] = 1; n_ls[p] = lsp[p]; end
        end
        for (int p = 0; p < NP; p++) begin
            m_stat[p] = n_stat[p]; m_rs[p] = n_rs[p]; m_cnt[p] = n_cnt[p];
            m_pres[p] = n_pres[p]; m_ls[p] = n_ls[p];
        end
        if (bwr && baddr == 0) m_ist = m_ist & ~bwdata;
        m_ist = m_ist | (isrc & 32'h4000_007F) | (hub ? 32'h40 : 32'h0);
        if (bwr && baddr == 1) m_ien = m_ien | bwdata;
        if (bwr && baddr == 2) m_ien = m_ien & ~bwdata;
        if (m_hc == 0) m_hc = hc_req ? 1 : 0;
        else if (m_hc == 1) m_hc = 2;
        else m_hc = 0;
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        att = '0; det = '0; bwr = 1'b0; isrc = '0; hc_req = 1'b0;
        read_all(tag);
    endtask

    task automatic wr(int a, logic [31:0] d, string tag);
        bwr = 1'b1; baddr = AW'(a); bwdata = d;
        tick(tag);
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_stat[p] = 0; m_rs[p] = 0; m_cnt[p] = 0; m_pres[p] = 0; m_ls[p] = 0;
        end
        m_ist = 0; m_ien = 0; m_hc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_all("R1");
        chk("R1 irq", {31'b0, irq_v}, 32'h0);
        chk("R2 unmapped", rd_v[5], 32'h0);

        att[0] = 1'b1; lsp[0] = 1'b0; tick("R3");
        chk("R3 port0", rd_v[3], 32'h0001_0001);
        chk("R3 hubchg", rd_v[0], 32'h0000_0040);
        att[1] = 1'b1; lsp[1] = 1'b1; tick("R3");
        chk("R3 port1 lowspeed", rd_v[4], 32'h0001_0201);

        wr(3, 32'h0001_0000, "R5");
        chk("R5 w1c", rd_v[3], 32'h0000_0001);
        wr(3, 32'h0000_0201, "R5");
        chk("R5 ro bits", rd_v[3], 32'h0000_0001);
        wr(3, 32'h0000_0102, "R6");
        chk("R6 enable+power", rd_v[3], 32'h0000_0103);

        wr(0, 32'h0000_0040, "R9");
        chk("R9 clear", rd_v[0], 32'h0);
        det[0] = 1'b1; tick("R4");
        chk("R4 detach", rd_v[3], 32'h0003_0100);
        chk("R4 hubchg", rd_v[0], 32'h40);
        wr(0, 32'h40, "R9");
        det[0] = 1'b1; tick("R4");
        chk("R4 idle detach word", rd_v[3], 32'h0003_0100);
        chk("R4 idle detach no irq bit", rd_v[0], 32'h0);

        wr(4, 32'h0000_0010, "R7");
        chk("R7 reset active", rd_v[4], 32'h0001_0211);
        repeat (RSTC - 1) tick("R7");
        chk("R7 still resetting", rd_v[4], 32'h0001_0211);
        tick("R7");
        chk("R7 reset done", rd_v[4], 32'h0011_0203);
        chk("R7 hubchg", rd_v[0], 32'h40);
        wr(4, 32'h0000_0004, "R6");
        chk("R6 suspend", rd_v[4], 32'h0011_0207);
        wr(4, 32'h0000_0008, "R6");
        chk("R6 resume", rd_v[4], 32'h0015_0203);

        oc[0] = 1'b1; tick("R8");
        chk("R8 oc high", rd_v[3], 32'h000B_0108);
        oc[0] = 1'b0; tick("R8");
        chk("R8 oc low", rd_v[3], 32'h000B_0100);

        wr(0, 32'hFFFF_FFFF, "R9");
        wr(1, 32'h0000_0040, "R10");
        det[1] = 1'b1; tick("R10");
        chk("R10 no master", {31'b0, irq_v}, 32'h0);
        wr(1, 32'h8000_0000, "R10");
        chk("R10 master", {31'b0, irq_v}, 32'h1);
        wr(2, 32'h8000_0000, "R10");
        chk("R10 master off", {31'b0, irq_v}, 32'h0);
        isrc = 32'hC000_0080; tick("R9");
        chk("R9 latch mask", rd_v[0], 32'h4000_0040);

        att[0] = 1'b1; lsp[0] = 1'b0; tick("R11");
        hc_req = 1'b1; tick("R11");
        tick("R11");
        chk("R11 cleared", rd_v[3], 32'h0);
        tick("R11");
        chk("R11 replay present", rd_v[3], 32'h0001_0001);
        chk("R11 replay absent", rd_v[4], 32'h0);

        att[0] = 1'b1; bwr = 1'b1; baddr = 3'd3; bwdata = 32'h0001_0000; tick("R12");
        chk("R12 event after write", rd_v[3], 32'h0001_0001);
        att[1] = 1'b1; det[1] = 1'b1; tick("R12");
        chk("R12 detach wins", rd_v[4], 32'h0);

        begin
            int unsigned r;
            r = $urandom(32'd20240601);
            for (int c = 0; c < 4000; c++) begin
                for (int p = 0; p < NP; p++) begin
                    r = $urandom % 100;
                    if (r < 4) att[p] = 1'b1;
                    else if (r < 7) det[p] = 1'b1;
                    else if (r < 8) begin att[p] = 1'b1; det[p] = 1'b1; end
                    lsp[p] = $urandom % 2;
                    if ($urandom % 100 < 2) oc[p] = ~oc[p];
                end
                if ($urandom % 100 < 35) begin
                    bwr = 1'b1;
                    baddr = AW'($urandom % 6);
                    bwdata = $urandom & 32'h801F_037F;
                end
                if ($urandom % 100 < 8) isrc = 32'h1 << ($urandom % 32);
                if ($urandom % 1000 < 3) hc_req = 1'b1;
                tick("R12");
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule